// File: doc/BRIEF.md
# Instruction Tag Tracking Trigger

This block watches opcode fetches against a set of address comparators and turns matches into transition requests for a small state sequencer. Each comparator works in one of two modes. In immediate mode a match on an accepted fetch moves the sequencer at once. In tag mode the match does not act directly. Instead it marks the fetched opcode, and that mark travels with the instruction through a three-stage instruction queue. It fires only when the instruction sits at the queue head and the core signals that it executes.

The sequencer leaves idle when armed and then walks through three intermediate states. In each state, a per-state table chooses the next state for every comparator. Entering the final state starts a trace session. The session counts executed instructions as trace lines. When the programmed number of lines is stored, the sequencer returns to idle and a breakpoint request pulses for one cycle, so no breakpoint can be raised while tracing is still in progress.

Top module: `tag_trigger_unit`

## Requirements
- R1: After reset the sequencer is idle (code 0), the queue holds no tags, `trace_active` and `brk_pulse` are low and `tag_hit` is zero.
- R2: A comparator with its tag-mode bit clear, enabled, whose address equals `fetch_addr` while `fetch_valid` and `q_shift` are high, moves the sequencer on that clock edge to the state selected for it.
- R3: A comparator with its tag-mode bit set does not move the sequencer on its match. Its tag enters queue stage 0 and advances one stage per `q_shift`, so it reaches the head after three shifts. `tag_hit[c]` is then high in any cycle where `exec_strobe` is high, and the sequencer takes the transition for comparator c on that edge.
- R4: `tag_hit` is zero whenever `exec_strobe` is low or the head holds no tag. A tag that is shifted past the head without `exec_strobe` is lost.
- R5: `q_flush` clears every tag in the queue and drops the fetch of that cycle. The cycle after a flush, `tag_hit` is zero even with `exec_strobe` high.
- R6: When an immediate match and a tag hit occur in the same cycle, only the immediate matches steer the sequencer. Among comparators with events and usable entries, the lowest index wins.
- R7: State codes are idle=0, state1=1, state2=2, state3=3, final=4. `next_cfg` bits [((s-1)*NCMP+c)*3 +: 3] give the target of comparator c in state s (1..3). A target of 0 or above 4 makes that comparator ignored in that state.
- R8: In idle, comparator events are ignored and `arm` moves the sequencer to state1.
- R9: `trace_active` is high exactly while in the final state. Entering the final state loads `trace_len`. Each `exec_strobe` cycle in the final state counts one line. The cycle that stores line max(`trace_len`,1) returns the sequencer to idle and raises `brk_pulse` for exactly one cycle.
- R10: `brk_pulse` stays low during the trace session and is never raised outside the end of one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Leave idle for state1 |
| fetch_valid | input | 1 | Opcode fetch present this cycle |
| fetch_addr | input | AW | Address of the fetched opcode |
| q_shift | input | 1 | Advance the instruction queue and accept the fetch |
| q_flush | input | 1 | Discard all queue contents |
| exec_strobe | input | 1 | Head instruction executes this cycle |
| cmp_en | input | NCMP | Comparator enables |
| cmp_tag_mode | input | NCMP | Per comparator: 1 = tag mode, 0 = immediate |
| cmp_addr | input | NCMP*AW | Comparator addresses, comparator c at [c*AW +: AW] |
| next_cfg | input | 9*NCMP | Per-state target table |
| trace_len | input | CW | Number of trace lines per session |
| tag_hit | output | NCMP | Tag hit per comparator |
| seq_state | output | 3 | Current sequencer state code |
| trace_active | output | 1 | Trace session in progress |
| brk_pulse | output | 1 | One-cycle breakpoint request |

## Verification
A tag that sits in the wrong stage or survives a flush shows at the ports as `tag_hit` rising a shift too early, too late, or after the flush. It also shows as `seq_state` changing on the following edge, so the error becomes visible within one cycle of the strobe. A wrong sequencer state or line count shows as the wrong `seq_state` code right after the transition edge, or as `brk_pulse` arriving a line early or late. The bench therefore samples `tag_hit` inside the strobe cycle and the state and pulse one edge later.

// File: rtl/tag_trigger_unit.sv
module tag_trigger_unit #(
  parameter int NCMP   = 3,
  parameter int AW     = 16,
  parameter int QDEPTH = 3,
  parameter int CW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              fetch_valid,
  input  logic [AW-1:0]     fetch_addr,
  input  logic              q_shift,
  input  logic              q_flush,
  input  logic              exec_strobe,
  input  logic [NCMP-1:0]   cmp_en,
  input  logic [NCMP-1:0]   cmp_tag_mode,
  input  logic [NCMP*AW-1:0] cmp_addr,
  input  logic [9*NCMP-1:0] next_cfg,
  input  logic [CW-1:0]     trace_len,
  output logic [NCMP-1:0]   tag_hit,
  output logic [2:0]        seq_state,
  output logic              trace_active,
  output logic              brk_pulse
);
  localparam logic [2:0] ST_IDLE  = 3'd0;
  localparam logic [2:0] ST_ONE   = 3'd1;
  localparam logic [2:0] ST_FINAL = 3'd4;

  logic [NCMP-1:0] match, imm_hit, evt;
  logic [NCMP-1:0] q_tag [QDEPTH];
  logic [2:0]      nxt_sel;
  logic [CW-1:0]   lines_left;

  for (genvar c = 0; c < NCMP; c++) begin : g_cmp
    assign match[c] = cmp_en[c] && fetch_valid && q_shift && !q_flush &&
                      (fetch_addr == cmp_addr[c*AW +: AW]);
  end

  assign imm_hit      = match & ~cmp_tag_mode;
  assign tag_hit      = exec_strobe ? q_tag[QDEPTH-1] : '0;
  assign evt          = (|imm_hit) ? imm_hit : tag_hit;
  assign trace_active = (seq_state == ST_FINAL);

  always_ff @(posedge clk) begin
    if (!rst_n || q_flush) begin
      for (int k = 0; k < QDEPTH; k++) q_tag[k] <= '0;
    end else if (q_shift) begin
      q_tag[0] <= match & cmp_tag_mode;
      for (int k = 1; k < QDEPTH; k++) q_tag[k] <= q_tag[k-1];
    end
  end

  always_comb begin
    logic       found;
    logic [2:0] fld;
    int         idx;
    nxt_sel = seq_state;
    found   = 1'b0;
    fld     = '0;
    idx     = 0;
    if (seq_state >= ST_ONE && seq_state < ST_FINAL) begin
      for (int c = 0; c < NCMP; c++) begin
        idx = (int'(seq_state) - 1) * NCMP + c;
        fld = next_cfg[idx*3 +: 3];
        if (!found && evt[c] && fld != ST_IDLE && fld <= ST_FINAL) begin
          nxt_sel = fld;
          found   = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_state  <= ST_IDLE;
      lines_left <= '0;
      brk_pulse  <= 1'b0;
    end else begin
      brk_pulse <= 1'b0;
      if (seq_state == ST_IDLE) begin
        if (arm) seq_state <= ST_ONE;
      end else if (seq_state == ST_FINAL) begin
        if (exec_strobe) begin
          if (lines_left <= CW'(1)) begin
            seq_state <= ST_IDLE;
            brk_pulse <= 1'b1;
          end else begin
            lines_left <= lines_left - CW'(1);
          end
        end
      end else if (nxt_sel != seq_state) begin
        seq_state <= nxt_sel;
        if (nxt_sel == ST_FINAL) lines_left <= trace_len;
      end
    end
  end

  assert_taghit_needs_exec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|tag_hit) |-> exec_strobe);

  assert_flush_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(q_flush) |-> (tag_hit == '0));

  assert_state_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seq_state <= ST_FINAL);

  assert_idle_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_state == ST_IDLE && !arm) |=> (seq_state == ST_IDLE));

  assert_brk_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    brk_pulse |=> !brk_pulse);

  assert_brk_after_trace_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_pulse) |-> ($past(seq_state) == ST_FINAL && seq_state == ST_IDLE));
endmodule

// File: tb/test_tag_trigger_unit.sv
module test_tag_trigger_unit;
  localparam int NCMP = 3, AW = 16, CW = 8;

  logic clk = 1'b0, rst_n = 1'b0, arm = 1'b0;
  logic fetch_valid = 1'b0, q_shift = 1'b0, q_flush = 1'b0, exec_strobe = 1'b0;
  logic [AW-1:0] fetch_addr = '0;
  logic [NCMP-1:0] cmp_en = '1, cmp_tag_mode = '0;
  logic [NCMP*AW-1:0] cmp_addr = '0;
  logic [9*NCMP-1:0] next_cfg = '0;
  logic [CW-1:0] trace_len = '0;
  logic [NCMP-1:0] tag_hit;
  logic [2:0] seq_state;
  logic trace_active, brk_pulse;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tag_trigger_unit #(.NCMP(NCMP), .AW(AW), .QDEPTH(3), .CW(CW)) i_tag_trigger_unit (
    .clk(clk), .rst_n(rst_n), .arm(arm), .fetch_valid(fetch_valid),
    .fetch_addr(fetch_addr), .q_shift(q_shift), .q_flush(q_flush),
    .exec_strobe(exec_strobe), .cmp_en(cmp_en), .cmp_tag_mode(cmp_tag_mode),
    .cmp_addr(cmp_addr), .next_cfg(next_cfg), .trace_len(trace_len),
    .tag_hit(tag_hit), .seq_state(seq_state), .trace_active(trace_active),
    .brk_pulse(brk_pulse));

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_cfg(int s, int c, logic [2:0] v);
    next_cfg[((s - 1) * NCMP + c) * 3 +: 3] = v;
  endtask

  task automatic push(logic [AW-1:0] a, logic v);
    fetch_addr = a; fetch_valid = v; q_shift = 1'b1;
    cyc();
    q_shift = 1'b0; fetch_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 state", seq_state, 0);
    chk("R1 trace", trace_active, 0);
    chk("R1 brk", brk_pulse, 0);
    exec_strobe = 1'b1; #1;
    chk("R1 tag_hit", tag_hit, 0);
    exec_strobe = 1'b0;
  endtask

  task automatic t_arm();
    push(16'h0100, 1'b1);
    chk("R8 idle ignores match", seq_state, 0);
    arm = 1'b1; cyc(); arm = 1'b0;
    chk("R8 arm to state1", seq_state, 1);
  endtask

  task automatic t_immediate();
    push(16'h0100, 1'b1);
    chk("R2 immediate to state2", seq_state, 2);
  endtask

  task automatic t_ignore_field();
    set_cfg(2, 0, 3'd0); set_cfg(2, 1, 3'd7);
    push(16'h0100, 1'b1);
    chk("R7 target 0 ignored", seq_state, 2);
    push(16'h0200, 1'b1);
    chk("R7 target 7 ignored", seq_state, 2);
  endtask

  task automatic t_tag_travel();
    set_cfg(2, 2, 3'd3);
    cmp_tag_mode = 3'b100;
    push(16'h0300, 1'b1);
    chk("R3 tag match no jump", seq_state, 2);
    exec_strobe = 1'b1; #1;
    chk("R3 tag in stage0 no hit", tag_hit, 0);
    push(16'h0000, 1'b0);
    chk("R3 tag in stage1 no hit", tag_hit, 0);
    push(16'h0000, 1'b0);
    exec_strobe = 1'b0; #1;
    chk("R4 head tag without exec", tag_hit, 0);
    exec_strobe = 1'b1; #1;
    chk("R3 tag hit at head", tag_hit, 3'b100);
    q_shift = 1'b1; cyc(); q_shift = 1'b0; exec_strobe = 1'b0;
    chk("R3 tag hit moves to state3", seq_state, 3);
  endtask

  task automatic t_flush();
    set_cfg(3, 2, 3'd4);
    push(16'h0300, 1'b1);
    push(16'h0000, 1'b0);
    q_flush = 1'b1; cyc(); q_flush = 1'b0;
    exec_strobe = 1'b1; #1;
    chk("R5 no hit after flush", tag_hit, 0);
    push(16'h0000, 1'b0);
    push(16'h0000, 1'b0);
    exec_strobe = 1'b0;
    chk("R5 flushed tag never fires", seq_state, 3);
  endtask

  task automatic t_shift_out();
    push(16'h0300, 1'b1);
    push(16'h0000, 1'b0);
    push(16'h0000, 1'b0);
    push(16'h0000, 1'b0);
    exec_strobe = 1'b1; #1;
    chk("R4 tag lost past head", tag_hit, 0);
    cyc(); exec_strobe = 1'b0;
    chk("R4 no jump after loss", seq_state, 3);
  endtask

  task automatic t_priority();
    set_cfg(3, 0, 3'd1);
    push(16'h0300, 1'b1);
    push(16'h0000, 1'b0);
    push(16'h0000, 1'b0);
    exec_strobe = 1'b1; fetch_addr = 16'h0100; fetch_valid = 1'b1; q_shift = 1'b1; #1;
    chk("R6 tag hit visible", tag_hit, 3'b100);
    cyc();
    exec_strobe = 1'b0; fetch_valid = 1'b0; q_shift = 1'b0;
    chk("R6 immediate beats tag", seq_state, 1);
    cmp_addr[AW +: AW] = 16'h0100;
    set_cfg(1, 1, 3'd3);
    push(16'h0100, 1'b1);
    chk("R6 lowest index wins", seq_state, 2);
    cmp_addr[AW +: AW] = 16'h0200;
  endtask

  task automatic t_trace();
    set_cfg(2, 0, 3'd4);
    trace_len = 8'd3;
    push(16'h0100, 1'b1);
    chk("R9 final state", seq_state, 4);
    chk("R9 trace active", trace_active, 1);
    exec_strobe = 1'b1; cyc(); exec_strobe = 1'b0;
    chk("R10 no brk line1", brk_pulse, 0);
    cyc();
    chk("R9 idle cycle no count", trace_active, 1);
    exec_strobe = 1'b1; cyc(); exec_strobe = 1'b0;
    chk("R10 no brk line2", brk_pulse, 0);
    chk("R9 still tracing", trace_active, 1);
    exec_strobe = 1'b1; cyc(); exec_strobe = 1'b0;
    chk("R9 brk at last line", brk_pulse, 1);
    chk("R9 back to idle", seq_state, 0);
    chk("R9 trace stops", trace_active, 0);
    cyc();
    chk("R9 brk one cycle", brk_pulse, 0);
  endtask

  task automatic t_zero_len();
    trace_len = 8'd0;
    set_cfg(1, 0, 3'd4);
    arm = 1'b1; cyc(); arm = 1'b0;
    push(16'h0100, 1'b1);
    chk("R9 zero length enters final", seq_state, 4);
    exec_strobe = 1'b1; cyc(); exec_strobe = 1'b0;
    chk("R9 zero length ends after one line", brk_pulse, 1);
    chk("R9 zero length idle", seq_state, 0);
  endtask

  initial begin
    cmp_addr[0 +: AW] = 16'h0100;
    cmp_addr[AW +: AW] = 16'h0200;
    cmp_addr[2*AW +: AW] = 16'h0300;
    set_cfg(1, 0, 3'd2);
    cyc(); cyc();
    rst_n = 1'b1;
    t_reset();
    t_arm();
    t_immediate();
    t_ignore_field();
    t_tag_travel();
    t_flush();
    t_shift_out();
    t_priority();
    t_trace();
    t_zero_len();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule